// File: doc/BRIEF.md
# Software STORE/RECALL Unlock Sequence Detector

This block sits beside an asynchronous SRAM-style bus and watches its read cycles for a fixed series of six addresses. When the series is complete, it starts a copy of the volatile array into its shadow nonvolatile array (STORE), or a copy back the other way (RECALL). The bus has no command pin. The command is the exact order of the reads, and each step is taken on a falling edge of the active-low chip enable. Output enable is not an input, because it plays no part in the sequence.

The chip enable, write enable and address inputs are passed through two-flop synchronisers into the system clock domain. A falling edge of the synchronised chip enable produces one registered access event. That event captures the address and whether the access was a write. A state machine steps through the states ST_IDLE, ST_HAVE1, ST_HAVE2, ST_HAVE3, ST_HAVE4 and ST_HAVE5, one for each address matched so far, and then enters ST_XFER. While the machine is in ST_XFER, the busy output holds the memory interface off for a parameterised number of clocks. That number is set separately for STORE and for RECALL.

The transitions are as follows:
- advance: a read to the next expected address moves one state forward.
- restart: a read to 0x0000 that does not advance moves to ST_HAVE1.
- abort: any other read, or any write, returns to ST_IDLE.
- launch: in ST_HAVE5, a read to 0x0F0F starts a STORE and a read to 0x0C63 starts a RECALL.
- finish: when the transfer timer expires, ST_XFER returns to ST_IDLE.

Top module: `nv_unlock_detector`

## Requirements
- R1: Six read accesses to 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order, produce exactly one store_start pulse.
- R2: The same first five reads followed by a read to 0x0C63 produce exactly one recall_start pulse.
- R3: Only a falling edge of ce_n counts as an access. Changes on addr or we_n while ce_n is held steady, low or high, have no effect on the sequence.
- R4: An access taken with we_n low (a write) aborts the sequence to ST_IDLE. The remaining reads of the sequence then start nothing.
- R5: A read to an address that is not the next expected one aborts to ST_IDLE. If that address is 0x0000, it is taken as step one of a new sequence, so a repeated 0x0000 followed by the rest of the sequence still triggers.
- R6: busy is high for exactly STORE_CYCLES clocks after a STORE launch and for exactly RECALL_CYCLES clocks after a RECALL launch. It rises in the same cycle as the start pulse.
- R7: Chip-enable edges that arrive while busy is high are ignored. After busy falls the machine is in ST_IDLE, so a lone final address starts nothing.
- R8: store_start and recall_start each last one clock and are never high together.
- R9: After reset, busy, store_start and recall_start are low and the machine is in ST_IDLE.
- R10: busy rises only together with a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| addr | input | 13 | Bus address, asynchronous |
| store_start | output | 1 | One-clock pulse that launches a STORE |
| recall_start | output | 1 | One-clock pulse that launches a RECALL |
| busy | output | 1 | High while a transfer runs; the memory interface is disabled |

## Verification
On every cycle, the assertions check the following: start pulses are one clock wide, the two pulses never overlap, busy rises only with a start pulse, no pulse appears inside a running transfer, the timer counts down by one each clock, and access events are one clock wide. Some behaviours are visible only through the bench's scenarios. These are the exact address order that triggers, the aborts on writes and stray addresses, the restart on 0x0000, the insensitivity to address changes without a chip-enable edge, the exact busy lengths, and the dropping of edges that arrive during a transfer.

// File: rtl/nvu_pkg.sv
package nvu_pkg;

    localparam int ADDR_W = 13;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HAVE1 = 3'd1,
        ST_HAVE2 = 3'd2,
        ST_HAVE3 = 3'd3,
        ST_HAVE4 = 3'd4,
        ST_HAVE5 = 3'd5,
        ST_XFER  = 3'd6
    } seq_state_t;

    localparam logic [ADDR_W-1:0] STORE_KEY  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] RECALL_KEY = 13'h0C63;

    // Address expected in state ST_IDLE + idx.
    function automatic logic [ADDR_W-1:0] key_addr(input int unsigned idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            0:       a = 13'h0000;
            1:       a = 13'h1555;
            2:       a = 13'h0AAA;
            3:       a = 13'h1FFF;
            default: a = 13'h10F0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nvu_bus_sampler.sv
module nvu_bus_sampler #(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ev_valid,
    output logic              ev_wr,
    output logic [ADDR_W-1:0] ev_addr
);
    localparam int LAST = SYNC_STAGES - 1;

    logic              ce_q   [SYNC_STAGES];
    logic              we_q   [SYNC_STAGES];
    logic [ADDR_W-1:0] addr_q [SYNC_STAGES];
    logic              ce_prev;
    logic              ce_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q[0]   <= 1'b1;
            we_q[0]   <= 1'b1;
            addr_q[0] <= '0;
        end else begin
            ce_q[0]   <= ce_n;
            we_q[0]   <= we_n;
            addr_q[0] <= addr;
        end
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ce_q[s]   <= 1'b1;
                we_q[s]   <= 1'b1;
                addr_q[s] <= '0;
            end else begin
                ce_q[s]   <= ce_q[s-1];
                we_q[s]   <= we_q[s-1];
                addr_q[s] <= addr_q[s-1];
            end
        end
    end

    assign ce_fall = ce_prev & ~ce_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_prev  <= 1'b1;
            ev_valid <= 1'b0;
            ev_wr    <= 1'b0;
            ev_addr  <= '0;
        end else begin
            ce_prev  <= ce_q[LAST];
            ev_valid <= ce_fall;
            if (ce_fall) begin
                ev_wr   <= ~we_q[LAST];
                ev_addr <= addr_q[LAST];
            end
        end
    end

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ev_valid); // R3

endmodule

// File: rtl/nvu_xfer_timer.sv
module nvu_xfer_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6

endmodule

// File: rtl/nvu_seq_fsm.sv
module nvu_seq_fsm
    import nvu_pkg::*;
#(
    parameter int STORE_CYCLES  = 2000,
    parameter int RECALL_CYCLES = 2000,
    parameter int CNT_W         = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_wr,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              store_start,
    output logic              recall_start,
    output logic              busy
);
    seq_state_t state, nxt;
    logic       trig_st, trig_rc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt     = state;
        trig_st = 1'b0;
        trig_rc = 1'b0;
        unique case (state)
            ST_XFER: begin
                if (tmr_zero) nxt = ST_IDLE;                 // finish
            end
            ST_HAVE5: begin
                if (ev_valid) begin
                    if (ev_wr)                          nxt = ST_IDLE;
                    else if (ev_addr == STORE_KEY)  begin nxt = ST_XFER; trig_st = 1'b1; end
                    else if (ev_addr == RECALL_KEY) begin nxt = ST_XFER; trig_rc = 1'b1; end
                    else if (ev_addr == key_addr(0))    nxt = ST_HAVE1;
                    else                                nxt = ST_IDLE;
                end
            end
            default: begin
                if (ev_valid) begin
                    if (ev_wr)                                       nxt = ST_IDLE;
                    else if (ev_addr == key_addr(int'(state)))       nxt = seq_state_t'(state + 3'd1);
                    else if (ev_addr == key_addr(0))                 nxt = ST_HAVE1;
                    else                                             nxt = ST_IDLE;
                end
            end
        endcase
    end

    assign tmr_load = trig_st | trig_rc;
    assign tmr_val  = trig_st ? CNT_W'(STORE_CYCLES - 1) : CNT_W'(RECALL_CYCLES - 1);
    assign busy     = (state == ST_XFER);

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_start  <= 1'b0;
            recall_start <= 1'b0;
        end else begin
            store_start  <= trig_st;
            recall_start <= trig_rc;
        end
    end

    AST_STORE_ONE_SHOT:  assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> !store_start); // R8
    AST_RECALL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start |=> !recall_start); // R8
    AST_START_EXCL:      assert property (@(posedge clk) disable iff (!rst_n)
        !(store_start && recall_start)); // R8
    AST_START_BUSY:      assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> busy); // R6
    AST_BUSY_ENTRY:      assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_start || recall_start)); // R10
    AST_IGNORE_BUSY:     assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (!store_start && !recall_start)); // R7

endmodule

// File: rtl/nv_unlock_detector.sv
module nv_unlock_detector
    import nvu_pkg::*;
#(
    parameter int STORE_CYCLES  = 2000,
    parameter int RECALL_CYCLES = 2000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_start,
    output logic              recall_start,
    output logic              busy
);
    localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              ev_valid, ev_wr, tmr_zero, tmr_load;
    logic [ADDR_W-1:0] ev_addr;
    logic [CNT_W-1:0]  tmr_val;

    nvu_bus_sampler #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .ev_valid(ev_valid), .ev_wr(ev_wr), .ev_addr(ev_addr)
    );

    nvu_seq_fsm #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_wr(ev_wr), .ev_addr(ev_addr),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .store_start(store_start), .recall_start(recall_start), .busy(busy)
    );

    nvu_xfer_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

endmodule

// File: tb/nv_unlock_detector_tb_top.sv
module nv_unlock_detector_tb_top;
    localparam int ST_LEN = 60;
    localparam int RC_LEN = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic        store_start, recall_start, busy;

    always #4 clk = ~clk;

    nv_unlock_detector #(.STORE_CYCLES(ST_LEN), .RECALL_CYCLES(RC_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .store_start(store_start), .recall_start(recall_start), .busy(busy)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    int st_seen = 0, rc_seen = 0, busy_seen = 0, both_seen = 0;
    int exp_st = 0, exp_rc = 0, exp_busy = 0;
    int mst = 0;
    logic [12:0] keys [5];

    always @(negedge clk) begin
        if (rst_n) begin
            if (store_start)                 st_seen++;
            if (recall_start)                rc_seen++;
            if (busy)                        busy_seen++;
            if (store_start && recall_start) both_seen++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One bus access: ce_n falls once with addr/we_n stable.
    task automatic rd(input logic [12:0] a, input logic w);
        @(negedge clk);
        addr = a; we_n = w; ce_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    // Reference model of the sequence rules (R1 R2 R4 R5).
    function automatic int model_step(input logic [12:0] a, input logic w);
        int trig = 0;
        if (!w)                                  mst = 0;
        else if (mst == 5 && a == 13'h0F0F) begin mst = 0; trig = 1; end
        else if (mst == 5 && a == 13'h0C63) begin mst = 0; trig = 2; end
        else if (mst < 5 && a == keys[mst])      mst = mst + 1;
        else if (a == 13'h0000)                  mst = 1;
        else                                     mst = 0;
        return trig;
    endfunction

    task automatic account(input int trig);
        if (trig == 1) begin
            exp_st++; exp_busy += ST_LEN;
            repeat (ST_LEN + 10) @(negedge clk);
        end else if (trig == 2) begin
            exp_rc++; exp_busy += RC_LEN;
            repeat (RC_LEN + 10) @(negedge clk);
        end
    endtask

    task automatic op(input logic [12:0] a, input logic w);
        int t;
        rd(a, w);
        t = model_step(a, w);
        account(t);
    endtask

    task automatic full_seq(input logic [12:0] last);
        for (int i = 0; i < 5; i++) op(keys[i], 1'b1);
        op(last, 1'b1);
    endtask

    task automatic checkpoint(input string tag);
        check({tag, " store pulses"}, st_seen, exp_st);
        check({tag, " recall pulses"}, rc_seen, exp_rc);
        check({tag, " busy cycles (R6 R10)"}, busy_seen, exp_busy);
        check({tag, " overlap (R8)"}, both_seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        keys[0] = 13'h0000; keys[1] = 13'h1555; keys[2] = 13'h0AAA;
        keys[3] = 13'h1FFF; keys[4] = 13'h10F0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 busy", int'(busy), 0);
        check("R9 store_start", int'(store_start), 0);
        check("R9 recall_start", int'(recall_start), 0);

        // R1 store sequence
        full_seq(13'h0F0F);
        checkpoint("R1");
        // R2 recall sequence
        full_seq(13'h0C63);
        checkpoint("R2");

        // R3: ce_n held low, addresses sweep without edges
        @(negedge clk); addr = 13'h0000; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        void'(model_step(13'h0000, 1'b1));
        for (int i = 1; i < 5; i++) begin
            repeat (6) @(negedge clk); addr = keys[i];
        end
        repeat (6) @(negedge clk); addr = 13'h0F0F;
        repeat (6) @(negedge clk); ce_n = 1'b1;
        // ce_n held high, addresses and we_n toggling
        for (int i = 0; i < 5; i++) begin
            repeat (6) @(negedge clk); addr = keys[i]; we_n = ~we_n;
        end
        repeat (6) @(negedge clk); addr = 13'h0F0F; we_n = 1'b1;
        repeat (10) @(negedge clk);
        checkpoint("R3");

        // R4: write in the middle aborts
        op(13'h0000, 1'b1); op(13'h1555, 1'b1); op(13'h0AAA, 1'b1);
        op(13'h1FFF, 1'b0);
        op(13'h1FFF, 1'b1); op(13'h10F0, 1'b1); op(13'h0F0F, 1'b1);
        checkpoint("R4");
        full_seq(13'h0F0F);
        checkpoint("R4 recovery");

        // R5: stray address aborts; repeated 0x0000 restarts
        op(13'h0000, 1'b1); op(13'h1555, 1'b1); op(13'h1234, 1'b1);
        op(13'h0AAA, 1'b1); op(13'h1FFF, 1'b1); op(13'h10F0, 1'b1); op(13'h0F0F, 1'b1);
        checkpoint("R5 abort");
        op(13'h0000, 1'b1);
        full_seq(13'h0C63);
        checkpoint("R5 restart");

        // R7: edges during busy are ignored
        for (int i = 0; i < 5; i++) rd(keys[i], 1'b1);
        rd(13'h0F0F, 1'b1);
        mst = 0; exp_st++; exp_busy += ST_LEN;
        for (int i = 0; i < 5; i++) rd(keys[i], 1'b1);
        rd(13'h0F0F, 1'b1);
        repeat (ST_LEN + 10) @(negedge clk);
        op(13'h0F0F, 1'b1);
        repeat (10) @(negedge clk);
        checkpoint("R7");

        // Random mix, checked against the model (R1 R2 R4 R5)
        for (int n = 0; n < 60; n++) begin
            int r;
            logic [12:0] a;
            logic w;
            r = $urandom_range(0, 9);
            if (r < 7)       a = (mst < 5) ? keys[mst] : ($urandom_range(0, 1) ? 13'h0F0F : 13'h0C63);
            else if (r == 7) a = 13'h0000;
            else             a = 13'($urandom_range(0, 8191));
            w = ($urandom_range(0, 11) != 0);
            op(a, w);
            if (n % 10 == 9) checkpoint("R1 R2 R4 R5 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule